// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

A 1024-word by 8-bit storage array with two independent ports, left and right, each able to read or write any word in any clock cycle. Each port has an active-low select, a read/write control (high reads, low writes), an active-low output enable, an address, write data, registered read data with a valid flag, an active-low busy input and an active-low interrupt output. The valid flag takes the place of a high-impedance data bus: when it is low the read data carries no meaning.

The two highest addresses serve as mailboxes between the ports. Writing the all-ones address from the left port raises the right port's interrupt. The right port clears it by reading that address. The address one below works the same way in the other direction: the right port writes it and the left port reads it. Mailbox words keep their data like any other word, so the receiver reads the message and clears the interrupt with the same access. A low busy input blocks that port's writes, mailbox writes included, and marks its read data as not valid.

Top module: `dpram_mailbox`

## Requirements
- R1: After reset, both valid flags are low and both interrupt outputs are high.
- R2: A port with select low, read/write low and busy high stores its write data at its address on the clock edge.
- R3: A port with select low, read/write high, output enable low and busy high gets valid high and the addressed word on its read data on the cycle after the request.
- R4: With select high, or with output enable high, the port's valid flag is low on the next cycle. With select high, the port does not write whatever its read/write input says.
- R5: While a port's busy input is low, its write leaves the word unchanged and its valid flag is low on the next cycle.
- R6: A left-port write to address 0x3FF drives the right interrupt low on the next cycle and stores the data there.
- R7: A right-port access with select low and read/write high to address 0x3FF drives the right interrupt high on the next cycle, whatever its output enable and busy are.
- R8: A right-port write to address 0x3FE drives the left interrupt low. A left-port read access to 0x3FE drives it high again.
- R9: When one port writes a word and the other port reads that word in the same cycle, the read returns the data held before the write.
- R10: When both ports write the same address in the same cycle, the left port's data is stored.
- R11: When a mailbox write and the matching clearing read fall in the same cycle, the interrupt is driven low (the set wins).
- R12: A mailbox write blocked by a low busy input leaves the receiving interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy, active low, blocks writes |
| l_addr | input | 10 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_rvalid | output | 1 | Left read data valid |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_sel_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy, active low, blocks writes |
| r_addr | input | 10 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_rvalid | output | 1 | Right read data valid |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Two functions can fall in the same cycle: a mailbox write from one port that sets an interrupt, and the other port's read of that mailbox that clears it. The same overlap of a write and a read on one word also decides whether the reader sees the old data. Directed cycles drive both ports at one mailbox address, and random traffic limited to a few addresses that include both mailboxes brings out many more such overlaps. A behavioural model in the bench applies set-over-clear, old-data reads and left-wins writes. It checks both interrupts, both valid flags and all known read data on every clock.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  // A blocked write becomes no operation; reads still access the array.
  function automatic port_op_e decode_op(input logic sel_n, input logic rw,
                                         input logic busy_n);
    if (sel_n)      return OP_NONE;
    else if (rw)    return OP_READ;
    else if (busy_n) return OP_WRITE;
    else            return OP_NONE;
  endfunction

  // Read data is presented only when the output is enabled and not busy.
  function automatic logic shows_data(input port_op_e op, input logic oe_n,
                                      input logic busy_n);
    return (op == OP_READ) && !oe_n && busy_n;
  endfunction

endpackage

// File: rtl/dpm_port_ctl.sv
module dpm_port_ctl
  import dpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic rw,
  input  logic oe_n,
  input  logic busy_n,
  output logic wr_go,
  output logic rd_go,
  output logic rvalid
);

  port_op_e op;
  logic     show_now;

  assign op       = decode_op(sel_n, rw, busy_n);
  assign wr_go    = (op == OP_WRITE);
  assign rd_go    = (op == OP_READ);
  assign show_now = shows_data(op, oe_n, busy_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= show_now;
  end

  // R4: a deselected port shows no data on the following cycle
  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !rvalid);

  // R5: busy hides read data on the following cycle
  p_busy_hides_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> !rvalid);

  // R5: busy never lets a write through
  p_busy_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !wr_go);

endmodule

// File: rtl/dpm_mem_core.sv
module dpm_mem_core #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            we,
  input  logic [1:0]            re,
  input  logic [1:0][AW-1:0]    addr,
  input  logic [1:0][DW-1:0]    wdata,
  output logic [1:0][DW-1:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Port 1 (right) is applied first so port 0 (left) lands last: R10.
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      if (we[p]) store[addr[p]] <= wdata[p];
    end
  end

  // Reads use the pre-edge contents: R9.
  generate
    for (genvar g = 0; g < 2; g++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata[g] <= '0;
        else if (re[g]) rdata[g] <= store[addr[g]];
      end
    end
  endgenerate

endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;
    else if (clr) irq_n <= 1'b1;
  end

  // R6/R11: a mailbox write asserts the interrupt, even against a clear
  p_set_asserts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n);

  // R7: a clearing read without a set releases the interrupt
  p_clear_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n);

  // R12: without a set or a clear the interrupt holds
  p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic          l_busy_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  output logic          l_irq_n,
  input  logic          r_sel_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  input  logic          r_busy_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  output logic          r_irq_n
);

  // Index 0 is the left port, index 1 the right port.
  localparam logic [AW-1:0] MBOX_TO_R = {AW{1'b1}};
  localparam logic [AW-1:0] MBOX_TO_L = {AW{1'b1}} - 1'b1;

  function automatic logic [AW-1:0] inbox_of(input int side);
    return (side == 0) ? MBOX_TO_L : MBOX_TO_R;
  endfunction

  logic [1:0]         sel_n_v, rw_v, oe_n_v, busy_n_v;
  logic [1:0][AW-1:0] addr_v;
  logic [1:0][DW-1:0] wdata_v, rdata_v;
  logic [1:0]         wr_go, rd_go, rvalid_v;
  logic [1:0]         mbox_set, mbox_clr, irq_n_v;

  assign sel_n_v  = {r_sel_n,  l_sel_n};
  assign rw_v     = {r_rw,     l_rw};
  assign oe_n_v   = {r_oe_n,   l_oe_n};
  assign busy_n_v = {r_busy_n, l_busy_n};
  assign addr_v   = {r_addr,   l_addr};
  assign wdata_v  = {r_wdata,  l_wdata};

  generate
    for (genvar p = 0; p < 2; p++) begin : g_port
      dpm_port_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n_v[p]),
        .rw     (rw_v[p]),
        .oe_n   (oe_n_v[p]),
        .busy_n (busy_n_v[p]),
        .wr_go  (wr_go[p]),
        .rd_go  (rd_go[p]),
        .rvalid (rvalid_v[p])
      );

      // The opposite port posts into this port's inbox; this port drains it.
      assign mbox_set[p] = wr_go[1-p] && (addr_v[1-p] == inbox_of(p));
      assign mbox_clr[p] = rd_go[p]   && (addr_v[p]   == inbox_of(p));

      dpm_mbox_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (mbox_set[p]),
        .clr   (mbox_clr[p]),
        .irq_n (irq_n_v[p])
      );
    end
  endgenerate

  dpm_mem_core #(.AW(AW), .DW(DW)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_go),
    .re    (rd_go),
    .addr  (addr_v),
    .wdata (wdata_v),
    .rdata (rdata_v)
  );

  assign l_rdata  = rdata_v[0];
  assign r_rdata  = rdata_v[1];
  assign l_rvalid = rvalid_v[0];
  assign r_rvalid = rvalid_v[1];
  assign l_irq_n  = irq_n_v[0];
  assign r_irq_n  = irq_n_v[1];

  // R6: a left write to the right inbox lowers the right interrupt
  p_left_post_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel_n && !l_rw && l_busy_n && l_addr == MBOX_TO_R) |=> !r_irq_n);

  // R8: a right write to the left inbox lowers the left interrupt
  p_right_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_sel_n && !r_rw && r_busy_n && r_addr == MBOX_TO_L) |=> !l_irq_n);

endmodule

// File: tb/test_dpram_mailbox.sv
module test_dpram_mailbox;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_sel_n = 1, l_rw = 1, l_oe_n = 1, l_busy_n = 1;
  logic       r_sel_n = 1, r_rw = 1, r_oe_n = 1, r_busy_n = 1;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic       l_rvalid, r_rvalid, l_irq_n, r_irq_n;

  always #10 clk = ~clk;

  dpram_mailbox i_dpram_mailbox (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_rvalid(l_rvalid), .l_irq_n(l_irq_n),
    .r_sel_n(r_sel_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_rvalid(r_rvalid), .r_irq_n(r_irq_n)
  );

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";

  // Reference model: sparse word store and two interrupt levels.
  int mem [int];
  bit m_lirq = 1, m_rirq = 1;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: predict from the current inputs, advance, compare at negedge.
  task automatic tick();
    bit lw, rw_, lr, rr, ev_l, ev_r;
    int ed_l, ed_r;
    lw  = !l_sel_n && !l_rw && l_busy_n;
    rw_ = !r_sel_n && !r_rw && r_busy_n;
    lr  = !l_sel_n && l_rw;
    rr  = !r_sel_n && r_rw;
    ev_l = lr && !l_oe_n && l_busy_n;
    ev_r = rr && !r_oe_n && r_busy_n;
    ed_l = mem.exists(int'(l_addr)) ? mem[int'(l_addr)] : -1;
    ed_r = mem.exists(int'(r_addr)) ? mem[int'(r_addr)] : -1;
    if (rw_) mem[int'(r_addr)] = int'(r_wdata);
    if (lw)  mem[int'(l_addr)] = int'(l_wdata);
    if (lw && l_addr == 10'h3FF) m_rirq = 0;
    else if (rr && r_addr == 10'h3FF) m_rirq = 1;
    if (rw_ && r_addr == 10'h3FE) m_lirq = 0;
    else if (lr && l_addr == 10'h3FE) m_lirq = 1;
    @(negedge clk);
    chk("l_rvalid", int'(l_rvalid), int'(ev_l));
    chk("r_rvalid", int'(r_rvalid), int'(ev_r));
    chk("l_irq_n", int'(l_irq_n), int'(m_lirq));
    chk("r_irq_n", int'(r_irq_n), int'(m_rirq));
    if (ev_l && ed_l >= 0) chk("l_rdata", int'(l_rdata), ed_l);
    if (ev_r && ed_r >= 0) chk("r_rdata", int'(r_rdata), ed_r);
  endtask

  task automatic idle();
    l_sel_n = 1; r_sel_n = 1; l_rw = 1; r_rw = 1;
    l_oe_n = 1; r_oe_n = 1; l_busy_n = 1; r_busy_n = 1;
  endtask

  task automatic lwr(logic [9:0] a, logic [7:0] d);
    l_sel_n = 0; l_rw = 0; l_addr = a; l_wdata = d;
  endtask
  task automatic rwr(logic [9:0] a, logic [7:0] d);
    r_sel_n = 0; r_rw = 0; r_addr = a; r_wdata = d;
  endtask
  task automatic lrd(logic [9:0] a);
    l_sel_n = 0; l_rw = 1; l_oe_n = 0; l_addr = a;
  endtask
  task automatic rrd(logic [9:0] a);
    r_sel_n = 0; r_rw = 1; r_oe_n = 0; r_addr = a;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("l_rvalid", int'(l_rvalid), 0);
    chk("r_rvalid", int'(r_rvalid), 0);
    chk("l_irq_n", int'(l_irq_n), 1);
    chk("r_irq_n", int'(r_irq_n), 1);
    rst_n = 1;
    @(negedge clk);

    tag = "R2"; idle(); lwr(10'h010, 8'hA5); tick();
    idle(); rrd(10'h010); tick();
    chk("r_rdata direct", int'(r_rdata), 8'hA5);
    tag = "R3"; idle(); lrd(10'h010); tick();
    chk("l_rdata direct", int'(l_rdata), 8'hA5);

    tag = "R4"; idle(); r_rw = 1; r_oe_n = 0; r_addr = 10'h010; tick();
    idle(); rrd(10'h010); r_oe_n = 1; tick();
    idle(); r_sel_n = 1; r_rw = 0; r_addr = 10'h010; r_wdata = 8'h00; tick();
    idle(); lrd(10'h010); tick();
    chk("ignored write", int'(l_rdata), 8'hA5);

    tag = "R5"; idle(); lwr(10'h010, 8'h3C); l_busy_n = 0; tick();
    idle(); rrd(10'h010); r_busy_n = 0; tick();
    idle(); rrd(10'h010); tick();
    chk("blocked write", int'(r_rdata), 8'hA5);

    tag = "R6"; idle(); lwr(10'h3FF, 8'h77); tick();
    chk("r_irq_n set", int'(r_irq_n), 0);
    tag = "R7"; idle(); rrd(10'h3FF); r_busy_n = 0; r_oe_n = 1; tick();
    chk("r_irq_n clear", int'(r_irq_n), 1);
    idle(); rrd(10'h3FF); tick();
    chk("mailbox data", int'(r_rdata), 8'h77);

    tag = "R8"; idle(); rwr(10'h3FE, 8'h11); tick();
    chk("l_irq_n set", int'(l_irq_n), 0);
    idle(); lrd(10'h3FE); l_oe_n = 1; tick();
    chk("l_irq_n clear", int'(l_irq_n), 1);

    tag = "R9"; idle(); lwr(10'h020, 8'h01); tick();
    idle(); lwr(10'h020, 8'h02); rrd(10'h020); tick();
    chk("old data", int'(r_rdata), 8'h01);

    tag = "R10"; idle(); lwr(10'h030, 8'hAA); rwr(10'h030, 8'h55); tick();
    idle(); lrd(10'h030); tick();
    chk("left wins", int'(l_rdata), 8'hAA);

    tag = "R11"; idle(); lwr(10'h3FF, 8'h21); rrd(10'h3FF); tick();
    chk("set beats clear", int'(r_irq_n), 0);
    idle(); rrd(10'h3FF); tick();

    tag = "R12"; idle(); lwr(10'h3FF, 8'h99); l_busy_n = 0; tick();
    chk("blocked post", int'(r_irq_n), 1);
    idle(); rwr(10'h3FE, 8'h44); r_busy_n = 0; tick();
    chk("blocked post left", int'(l_irq_n), 1);

    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] pick [4];
      pick[0] = 10'h3FF; pick[1] = 10'h3FE; pick[2] = 10'h005; pick[3] = 10'h006;
      l_sel_n = ($urandom_range(0, 3) == 0);
      r_sel_n = ($urandom_range(0, 3) == 0);
      l_rw = $urandom_range(0, 1); r_rw = $urandom_range(0, 1);
      l_oe_n = ($urandom_range(0, 3) == 0);
      r_oe_n = ($urandom_range(0, 3) == 0);
      l_busy_n = ($urandom_range(0, 5) != 0);
      r_busy_n = ($urandom_range(0, 5) != 0);
      l_addr = pick[$urandom_range(0, 3)];
      r_addr = pick[$urandom_range(0, 3)];
      l_wdata = 8'($urandom); r_wdata = 8'($urandom);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule